// File: doc/BRIEF.md
# Wormhole 2D Mesh Router

This block is the switch that sits in every tile of a two-dimensional mesh. It has five ports: one toward each compass neighbour and one toward the tile it belongs to. Each port carries 32-bit flits in both directions at once. Variable-length packets cross it by wormhole switching. The header flit names the destination tile and says how many body flits follow. The router then reserves one output for the whole packet and frees it once the last flit has gone through.

Paths are chosen in dimension order. A packet first moves along X until its column matches. It then moves along Y until its row matches, and then it leaves on the local port. Each input holds a small FIFO. Each output keeps a credit count of the free slots in the neighbour's input buffer. A flit leaves only when that count is non-zero, and the router sends a credit pulse upstream for every flit it removes from an input FIFO. The tile coordinates of this router are set by parameters.

Top module: `mesh_router`

## Requirements
- R1: After a synchronous active-high reset, every `out_valid` and `in_credit` bit is 0, and each output holds 4 credits.
- R2: In a header flit, bits [7:4] give the destination X, bits [3:0] give the destination Y, and bits [12:8] give the number of body flits that follow (0 to 31).
- R3: Port indices are 0 local, 1 north (+Y), 2 south (-Y), 3 east (+X), 4 west (-X). A header whose destination X is above the router's X leaves on port 3, and one whose X is below leaves on port 4, whatever its Y.
- R4: A header whose X matches the router's X leaves on port 1 if its Y is higher and on port 2 if its Y is lower.
- R5: A header whose X and Y both match the router's coordinates leaves on the local port 0.
- R6: A flit written into an empty input on clock edge k appears on its output after edge k+1, with all 32 bits unchanged, provided the output is free and has a credit.
- R7: Once an output has sent a header with a non-zero body count, it carries only that packet's body flits, in order, until the last one has gone. Headers from other inputs wait.
- R8: When several inputs keep offering headers to one free output, grants rotate round-robin, so no input receives two grants in a row while another is waiting.
- R9: An output sends at most as many flits as it holds credits. It stalls at zero credits, and each `out_credit` pulse lets exactly one more flit through.
- R10: `in_credit[i]` pulses for exactly one cycle for each flit removed from input FIFO i, in the cycle after the flit leaves.
- R11: Packets headed for different outputs move in the same cycle, without interfering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 5 | One flit is offered on each set input |
| in_data | input | 5x32 | Incoming flit for each input port |
| in_credit | output | 5 | Credit returned upstream, one pulse per dequeued flit |
| out_valid | output | 5 | A flit is present on each set output |
| out_data | output | 5x32 | Outgoing flit for each output port |
| out_credit | input | 5 | Credit from the downstream buffer, one pulse per freed slot |

## Verification
The bench places headers on both sides of the router's own coordinates. A design that compares Y before X, or that uses the wrong inequality, sends those packets out of the wrong face. A second input's header is injected while a multi-flit packet is still passing. A router that re-arbitrates on every flit would slip that header in among the body flits. The bench also holds credits back and then returns them one at a time: a counter that wraps, or one that ignores returned credits, would either send a fifth flit or never resume. Two inputs contend for the same output over a long run, which catches a fixed-priority arbiter that starves one of them.

// File: rtl/router_pkg.sv
package router_pkg;
  localparam int NPORT   = 5;
  localparam int PW      = $clog2(NPORT);
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_EAST  = 3;
  localparam int P_WEST  = 4;
  localparam int COORD_W = 4;
  localparam int Y_LSB   = 0;
  localparam int X_LSB   = 4;
  localparam int LEN_LSB = 8;
  localparam int LEN_W   = 5;

  // X first, then Y, then eject (R3, R4, R5)
  function automatic logic [PW-1:0] dor_route(
    input logic [COORD_W-1:0] dst_x, input logic [COORD_W-1:0] dst_y,
    input logic [COORD_W-1:0] here_x, input logic [COORD_W-1:0] here_y);
    if (dst_x > here_x)      return PW'(P_EAST);
    else if (dst_x < here_x) return PW'(P_WEST);
    else if (dst_y > here_y) return PW'(P_NORTH);
    else if (dst_y < here_y) return PW'(P_SOUTH);
    else                     return PW'(P_LOCAL);
  endfunction
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  // DEPTH must be a power of two so the pointers wrap naturally
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop)  rp <= rp + AW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + (AW+1)'(1);
        2'b01:   cnt <= cnt - (AW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == (AW+1)'(DEPTH));
endmodule

// File: rtl/router_rr_pick.sv
module router_rr_pick #(
  parameter int N  = 5,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [IW-1:0] c;

  // search starts just after the last granted input
  always_comb begin
    idx = '0;
    any = 1'b0;
    c   = '0;
    for (int k = 1; k <= N; k++) begin
      c = IW'((int'(ptr) + k) % N);
      if (!any && req[c]) begin
        any = 1'b1;
        idx = c;
      end
    end
  end
endmodule

// File: rtl/router_outport.sv
module router_outport #(
  parameter int N       = 5,
  parameter int W       = 32,
  parameter int CREDITS = 4,
  parameter int LEN_LSB = 8,
  parameter int LEN_W   = 5,
  parameter int IW      = $clog2(N),
  parameter int CW      = $clog2(CREDITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        hdr_req,
  input  logic [N-1:0]        head_vld,
  input  logic [N-1:0][W-1:0] head_data,
  input  logic                credit_in,
  output logic [N-1:0]        take,
  output logic                out_valid,
  output logic [W-1:0]        out_data,
  output logic                locked,
  output logic [IW-1:0]       owner,
  output logic [CW-1:0]       credits
);
  logic [IW-1:0]    rr_ptr, rr_idx, src;
  logic             rr_any, send;
  logic [LEN_W-1:0] remain;
  logic [W-1:0]     flit;
  logic [LEN_W-1:0] flen;

  router_rr_pick #(.N(N), .IW(IW)) u_pick (
    .req(hdr_req), .ptr(rr_ptr), .idx(rr_idx), .any(rr_any)
  );

  always_comb begin
    if (locked) begin
      src  = owner;
      send = head_vld[owner] && (credits != '0);
    end else begin
      src  = rr_idx;
      send = rr_any && (credits != '0);
    end
    for (int k = 0; k < N; k++) take[k] = send && (src == IW'(k));
  end

  assign flit = head_data[src];
  assign flen = flit[LEN_LSB +: LEN_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      locked    <= 1'b0;
      owner     <= '0;
      remain    <= '0;
      rr_ptr    <= IW'(N - 1);
      credits   <= CW'(CREDITS);
    end else begin
      out_valid <= send;
      if (send) out_data <= flit;
      credits <= credits - CW'(send) + CW'(credit_in);
      if (send) begin
        if (locked) begin
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) locked <= 1'b0;
        end else begin
          rr_ptr <= src;
          if (flen != '0) begin
            locked <= 1'b1;
            owner  <= src;
            remain <= flen;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import router_pkg::*;
#(
  parameter int MY_X       = 2,
  parameter int MY_Y       = 2,
  parameter int FLIT_W     = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][FLIT_W-1:0]  in_data,
  output logic [NPORT-1:0]              in_credit,
  output logic [NPORT-1:0]              out_valid,
  output logic [NPORT-1:0][FLIT_W-1:0]  out_data,
  input  logic [NPORT-1:0]              out_credit
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);

  logic [NPORT-1:0]              f_empty, f_full, pop, busy;
  logic [NPORT-1:0][FLIT_W-1:0]  head;
  logic [NPORT-1:0][NPORT-1:0]   hdr_req;   // [output][input]
  logic [NPORT-1:0][NPORT-1:0]   take;      // [output][input]
  logic [NPORT-1:0]              lock_on;
  logic [NPORT-1:0][PW-1:0]      lock_src;
  logic [NPORT-1:0][CW-1:0]      cred;
  logic [PW-1:0]                 rt;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    router_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .push(in_valid[i]), .din(in_data[i]),
      .pop(pop[i]), .dout(head[i]),
      .empty(f_empty[i]), .full(f_full[i])
    );
  end

  always_comb begin
    busy    = '0;
    pop     = '0;
    hdr_req = '0;
    rt      = '0;
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (lock_on[o] && lock_src[o] == PW'(i)) busy[i] = 1'b1;
        if (take[o][i]) pop[i] = 1'b1;
      end
    end
    // an idle input's head flit is a header: route it
    for (int i = 0; i < NPORT; i++) begin
      rt = dor_route(head[i][X_LSB +: COORD_W], head[i][Y_LSB +: COORD_W],
                     COORD_W'(MY_X), COORD_W'(MY_Y));
      if (!f_empty[i] && !busy[i]) hdr_req[rt][i] = 1'b1;
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    router_outport #(
      .N(NPORT), .W(FLIT_W), .CREDITS(FIFO_DEPTH),
      .LEN_LSB(LEN_LSB), .LEN_W(LEN_W), .IW(PW), .CW(CW)
    ) u_out (
      .clk(clk), .rst(rst),
      .hdr_req(hdr_req[o]), .head_vld(~f_empty), .head_data(head),
      .credit_in(out_credit[o]),
      .take(take[o]),
      .out_valid(out_valid[o]), .out_data(out_data[o]),
      .locked(lock_on[o]), .owner(lock_src[o]), .credits(cred[o])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) in_credit <= '0;
    else     in_credit <= pop;
  end
endmodule

// File: rtl/router_checker.sv
module router_checker #(
  parameter int NPORT = 5,
  parameter int PW    = 3,
  parameter int CW    = 3,
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NPORT-1:0]           in_valid,
  input logic [NPORT-1:0]           in_credit,
  input logic [NPORT-1:0]           out_valid,
  input logic [NPORT-1:0]           f_full,
  input logic [NPORT-1:0]           f_empty,
  input logic [NPORT-1:0]           lock_on,
  input logic [NPORT-1:0][PW-1:0]   lock_src,
  input logic [NPORT-1:0][CW-1:0]   cred
);
  for (genvar g = 0; g < NPORT; g++) begin : g_chk
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      in_valid[g] |-> !f_full[g]); // R9
    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
      cred[g] <= CW'(DEPTH)); // R9
    AST_STALL_NO_CREDIT: assert property (@(posedge clk) disable iff (rst)
      (cred[g] == '0) |=> !out_valid[g]); // R9
    AST_CREDIT_FROM_POP: assert property (@(posedge clk) disable iff (rst)
      in_credit[g] |-> $past(!f_empty[g])); // R10
    AST_LOCK_OWNER: assert property (@(posedge clk) disable iff (rst)
      (lock_on[g] && $past(lock_on[g])) |-> $stable(lock_src[g])); // R7
  end
endmodule

bind mesh_router router_checker #(
  .NPORT(NPORT), .PW(PW), .CW(CW), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_credit(in_credit),
  .out_valid(out_valid), .f_full(f_full), .f_empty(f_empty),
  .lock_on(lock_on), .lock_src(lock_src), .cred(cred)
);

// File: tb/tb_mesh_router.sv
`timescale 1ns/1ps
module tb_mesh_router;
  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [4:0]       in_valid = '0;
  logic [4:0][31:0] in_data = '0;
  logic [4:0]       in_credit;
  logic [4:0]       out_valid;
  logic [4:0][31:0] out_data;
  logic [4:0]       out_credit;
  logic             auto_cr = 1'b0;
  logic [4:0]       man_cr = '0;

  int nchk = 0;
  int nfail = 0;
  int ocnt [5] = '{default: 0};
  int ccnt [5] = '{default: 0};
  logic [31:0] olog [5][64];
  logic timeout = 1'b0;

  always #5 clk = ~clk;

  assign out_credit = (auto_cr ? out_valid : 5'b0) | man_cr;

  mesh_router dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_credit(in_credit), .out_valid(out_valid), .out_data(out_data),
    .out_credit(out_credit)
  );

  // monitor: log every output flit and every credit pulse
  always @(negedge clk) begin
    for (int p = 0; p < 5; p++) begin
      if (out_valid[p]) begin
        olog[p][ocnt[p] % 64] = out_data[p];
        ocnt[p] = ocnt[p] + 1;
      end
      if (in_credit[p]) ccnt[p] = ccnt[p] + 1;
    end
  end

  // port: 0 L, 1 N, 2 S, 3 E, 4 W ; header {tag,seq,0,len,x,y}
  localparam logic [11:0] ROUTE_VEC [0:10] = '{
    12'h323, 12'h703, 12'hFF3, 12'h054, 12'h124, 12'h194,
    12'h231, 12'h2F1, 12'h202, 12'h212, 12'h220
  };

  function automatic logic [31:0] hdr(input logic [3:0] tag, input logic [7:0] seq,
                                      input logic [4:0] len, input logic [3:0] x,
                                      input logic [3:0] y);
    return {tag, seq, 7'd0, len, x, y};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run_all();
    int b0, b1, c0;
    logic [31:0] wh;
    // ---- R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1 in_credit after reset", 32'(in_credit), 32'd0);

    // ---- R9 / R1: east output starts with 4 credits, then stalls
    b0 = ocnt[3];
    c0 = ccnt[0];
    for (int k = 0; k < 6; k++) begin
      in_valid[0] = 1'b1;
      in_data[0]  = hdr(4'h0, 8'(k), 5'd0, 4'd3, 4'd2);
      @(negedge clk);
    end
    in_valid[0] = 1'b0;
    settle(5);
    chk("R1 R9 flits sent on initial credits", 32'(ocnt[3] - b0), 32'd4);
    chk("R9 stalled without credit", 32'(out_valid[3]), 32'd0);
    man_cr[3] = 1'b1; @(negedge clk); man_cr[3] = 1'b0;
    settle(3);
    chk("R9 one credit, one flit", 32'(ocnt[3] - b0), 32'd5);
    man_cr[3] = 1'b1; @(negedge clk); man_cr[3] = 1'b0;
    settle(3);
    chk("R9 second credit, second flit", 32'(ocnt[3] - b0), 32'd6);
    chk("R9 order of last flit", olog[3][(ocnt[3] - 1) % 64], hdr(4'h0, 8'd5, 5'd0, 4'd3, 4'd2));
    chk("R10 credit pulses for six dequeues", 32'(ccnt[0] - c0), 32'd6);
    for (int k = 0; k < 4; k++) begin
      man_cr[3] = 1'b1; @(negedge clk); man_cr[3] = 1'b0; @(negedge clk);
    end
    auto_cr = 1'b1;

    // ---- R2..R6, R10: routing table walked by one loop
    for (int v = 0; v < 11; v++) begin
      logic [3:0] vx, vy;
      int vp;
      vx = ROUTE_VEC[v][11:8];
      vy = ROUTE_VEC[v][7:4];
      vp = int'(ROUTE_VEC[v][3:0]);
      @(negedge clk);
      in_valid[0] = 1'b1;
      in_data[0]  = hdr(4'hA, 8'(v), 5'd0, vx, vy);
      @(negedge clk);
      in_valid[0] = 1'b0;
      @(negedge clk);
      chk($sformatf("R3 R4 R5 R6 route vec %0d out_valid", v), 32'(out_valid), 32'(5'b1 << vp));
      chk($sformatf("R2 R6 route vec %0d data", v), out_data[vp], hdr(4'hA, 8'(v), 5'd0, vx, vy));
      chk($sformatf("R10 route vec %0d credit", v), 32'(in_credit), 32'd1);
    end
    settle(2);

    // ---- R7 wormhole: west input packet of 3 bodies holds east
    b0 = ocnt[3];
    c0 = ccnt[4];
    wh = hdr(4'h4, 8'h00, 5'd3, 4'd3, 4'd2);
    in_valid[4] = 1'b1; in_data[4] = wh;
    @(negedge clk);
    in_data[4] = 32'hB0D1_0001;
    in_valid[0] = 1'b1; in_data[0] = hdr(4'h0, 8'h77, 5'd0, 4'd3, 4'd2);
    @(negedge clk);
    in_valid[0] = 1'b0;
    in_data[4] = 32'hB0D1_0002;
    @(negedge clk);
    in_data[4] = 32'hB0D1_0003;
    @(negedge clk);
    in_valid[4] = 1'b0;
    settle(8);
    chk("R7 east flit count", 32'(ocnt[3] - b0), 32'd5);
    chk("R7 header first", olog[3][(b0 + 0) % 64], wh);
    chk("R7 body 1", olog[3][(b0 + 1) % 64], 32'hB0D1_0001);
    chk("R7 body 2", olog[3][(b0 + 2) % 64], 32'hB0D1_0002);
    chk("R7 body 3", olog[3][(b0 + 3) % 64], 32'hB0D1_0003);
    chk("R7 waiting header after tail", olog[3][(b0 + 4) % 64], hdr(4'h0, 8'h77, 5'd0, 4'd3, 4'd2));
    chk("R10 west credit pulses", 32'(ccnt[4] - c0), 32'd4);

    // ---- R8 round robin: north and south both target local
    b1 = ocnt[0];
    for (int k = 0; k < 3; k++) begin
      in_valid[1] = 1'b1; in_data[1] = hdr(4'h1, 8'(k), 5'd0, 4'd2, 4'd2);
      in_valid[2] = 1'b1; in_data[2] = hdr(4'h2, 8'(k), 5'd0, 4'd2, 4'd2);
      @(negedge clk);
    end
    in_valid[1] = 1'b0; in_valid[2] = 1'b0;
    settle(8);
    chk("R8 local flit count", 32'(ocnt[0] - b1), 32'd6);
    for (int k = 0; k < 5; k++) begin
      chk($sformatf("R8 alternation at %0d", k),
          32'(olog[0][(b1 + k) % 64][31:28] != olog[0][(b1 + k + 1) % 64][31:28]), 32'd1);
    end

    // ---- R11 parallel progress to three outputs
    @(negedge clk);
    in_valid[0] = 1'b1; in_data[0] = hdr(4'h0, 8'h51, 5'd0, 4'd3, 4'd2);
    in_valid[1] = 1'b1; in_data[1] = hdr(4'h1, 8'h52, 5'd0, 4'd1, 4'd5);
    in_valid[2] = 1'b1; in_data[2] = hdr(4'h2, 8'h53, 5'd0, 4'd2, 4'd7);
    @(negedge clk);
    in_valid = '0;
    @(negedge clk);
    chk("R11 three outputs in one cycle", 32'(out_valid), 32'(5'b11010));
    chk("R11 west data", out_data[4], hdr(4'h1, 8'h52, 5'd0, 4'd1, 4'd5));
    chk("R11 north data", out_data[1], hdr(4'h2, 8'h53, 5'd0, 4'd2, 4'd7));
    settle(3);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    if (timeout) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule